// File: doc/BRIEF.md
# Burg Lattice Autoregressive Estimator

This block fits an autoregressive model to a frame of signed samples with the Burg lattice recursion. A frame is loaded through a valid/ready write port into an internal sample buffer. A start pulse then runs the estimator stage by stage on one multiply-accumulate unit and one bit-serial divider. The estimator needs no autocorrelation matrix, and it assumes nothing about samples outside the frame. Each stage finds a reflection coefficient from the forward and backward prediction errors. It then updates the model coefficients, the error power, and the two error sequences in place.

When the last stage has finished, a one-cycle `done` pulse is given. The model coefficients and the final error power can then be read through a combinational read port. They stay there until the next start. The sample buffer keeps its contents across runs, so the same frame can be estimated again without writing it a second time.

Write port rules: `in_ready` is high exactly while the block is idle. A sample is stored only in a cycle where both `in_valid` and `in_ready` are high. While a run is in progress, `in_ready` stays low and any offered sample is dropped without touching the buffer.

Top module: `burg_ar_est`

## Requirements
- R1: After reset `busy` and `done` are low, `in_ready` is high and `rd_data` reads 0 for every address.
- R2: A sample is written to buffer slot `in_addr` only when `in_valid` and `in_ready` are both high. `in_ready` is low during a run, and a sample offered then leaves the buffer unchanged.
- R3: A `start` seen while idle raises `busy` on the next cycle. `busy` stays high until `done` pulses for exactly one cycle, and `busy` is already low in that cycle. The run takes no more than 2·N·(P+1)+20·P+8 cycles.
- R4: The order-0 forward and backward errors are the samples. Each stage applies f_m(n) = f_{m-1}(n) + k_m·b_{m-1}(n-1) and b_m(n) = b_{m-1}(n-1) + k_m·f_{m-1}(n). The stage sums run over n = m..N-1 only. The read-back coefficients agree with an exact Burg fit within 0.02.
- R5: k_m = -2·Σ f_{m-1}(n)·b_{m-1}(n-1) / Σ (f_{m-1}(n)² + b_{m-1}(n-1)²), in Q1.15 with the magnitude truncated. When |k_m| would be 1 or more, it becomes ±32767, and it is never -32768.
- R6: When the denominator sum of a stage is zero, k_m is 0.
- R7: Coefficients are updated by a_m(i) = a_{m-1}(i) + k_m·a_{m-1}(m-i) for i < m, with every a_{m-1} read before any is replaced, and a_m(m) = k_m.
- R8: P_0 = floor(Σ x(n)² / N) and P_m = P_{m-1} - floor(k_m²·P_{m-1} / 2^30).
- R9: For `rd_addr` = i in 0..P-1, `rd_data` is a(i+1) with 15 fraction bits, sign-extended. For `rd_addr` = P it is the final error power, and any other address reads 0. The values hold from `done` until the next start.
- R10: A run started without new writes reuses the frame already in the buffer and gives the same results again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| in_valid | input | 1 | Sample offered on the write port |
| in_ready | output | 1 | Write port can accept a sample |
| in_addr | input | log2(N) | Buffer slot of the offered sample |
| in_data | input | W | Signed sample value |
| rd_addr | input | ceil(log2(P+2)) | Result select: coefficient index or error power |
| rd_data | output | 2·W | Selected result |

## Verification
A written sample lands at the clock edge that sees `in_valid` and `in_ready` both high. `busy` is checked on the cycle right after the start pulse. The bench counts the cycles until `done` and requires the pulse to arrive within the bound in R3. The results are due in the cycle of `done` itself, because `rd_data` is a combinational function of `rd_addr`. A monitor therefore sets each address half a clock after an edge, samples one nanosecond later, and compares with the values that a driver task queued. These expected values come from a floating-point Burg fit, or from exact values worked out by hand for the zero and constant frames. The results are read again well after `done` to confirm that they held.

// File: rtl/burg_pkg.sv
package burg_pkg;
  localparam int BURG_KW = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PZ,
    ST_ACC,
    ST_DST,
    ST_DWT,
    ST_COEF,
    ST_UPD
  } burg_state_e;
endpackage

// File: rtl/burg_acc.sv
module burg_acc #(
  parameter int EW  = 21,
  parameter int ACW = 49
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  en,
  input  logic signed [EW-1:0]  fa,
  input  logic signed [EW-1:0]  bb,
  output logic signed [ACW-1:0] num,
  output logic [ACW-1:0]        den
);
  localparam int PRW = 2 * EW;

  logic signed [PRW-1:0] p_fb, p_ff, p_bb;

  always_comb begin
    p_fb = fa * bb;
    p_ff = fa * fa;
    p_bb = bb * bb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num <= '0;
      den <= '0;
    end else if (clr) begin
      num <= '0;
      den <= '0;
    end else if (en) begin
      num <= num + ACW'(p_fb);
      den <= den + ACW'(p_ff) + ACW'(p_bb);
    end
  end
endmodule

// File: rtl/burg_div.sv
module burg_div #(
  parameter int ACW = 49,
  parameter int KW  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic signed [ACW-1:0] num,
  input  logic [ACW-1:0]        den,
  output logic                  vld,
  output logic signed [KW-1:0]  k
);
  localparam int FB  = KW - 1;
  localparam int RW  = ACW + 2;
  localparam int CNW = $clog2(FB + 1);
  localparam logic signed [KW-1:0] KMAX = {1'b0, {FB{1'b1}}};

  logic signed [RW-1:0] num_x;
  logic [RW-1:0] twice, den_x, rem_sh, rem, dsr;
  logic [FB-1:0] q, q_n;
  logic [CNW-1:0] cnt;
  logic run, num_neg, qbit;

  always_comb begin
    num_x  = RW'(num);
    twice  = (num_x[RW-1] ? RW'(-num_x) : RW'(num_x)) << 1;
    den_x  = RW'(den);
    rem_sh = rem << 1;
    qbit   = (rem_sh >= dsr);
    q_n    = {q[FB-2:0], qbit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld     <= 1'b0;
      k       <= '0;
      run     <= 1'b0;
      num_neg <= 1'b0;
      rem     <= '0;
      dsr     <= '0;
      q       <= '0;
      cnt     <= '0;
    end else begin
      vld <= 1'b0;
      if (start) begin
        num_neg <= num_x[RW-1];
        dsr     <= den_x;
        q       <= '0;
        cnt     <= '0;
        if (den == '0) begin
          k   <= '0;
          vld <= 1'b1;
        end else if (twice >= den_x) begin
          k   <= num_x[RW-1] ? KMAX : -KMAX;
          vld <= 1'b1;
        end else begin
          rem <= twice;
          run <= 1'b1;
        end
      end else if (run) begin
        rem <= qbit ? rem_sh - dsr : rem_sh;
        q   <= q_n;
        cnt <= cnt + CNW'(1);
        if (cnt == CNW'(FB - 1)) begin
          run <= 1'b0;
          vld <= 1'b1;
          k   <= num_neg ? $signed({1'b0, q_n}) : -$signed({1'b0, q_n});
        end
      end
    end
  end
endmodule

// File: rtl/burg_ar_est.sv
module burg_ar_est #(
  parameter int N = 64,
  parameter int P = 4,
  parameter int W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [$clog2(N)-1:0]    in_addr,
  input  logic signed [W-1:0]     in_data,
  input  logic [$clog2(P+2)-1:0]  rd_addr,
  output logic [2*W-1:0]          rd_data
);
  import burg_pkg::*;

  localparam int LOGN = $clog2(N);
  localparam int EW   = W + P + 1;
  localparam int ACW  = 2 * EW + LOGN + 1;
  localparam int KW   = BURG_KW;
  localparam int FR   = KW - 1;
  localparam int CW   = KW + P + 2;
  localparam int PW   = 2 * W;
  localparam int DW   = 2 * W;
  localparam int MW   = $clog2(P + 1);

  burg_state_e state;
  logic [LOGN-1:0] n, n_prev;
  logic [MW-1:0]   m;
  logic signed [W-1:0]  x_mem [N];
  logic signed [EW-1:0] f_mem [N];
  logic signed [EW-1:0] b_mem [N];
  logic signed [CW-1:0] coef  [P];
  logic [PW-1:0]        pwr, pwr_next;
  logic signed [KW-1:0] k_q;

  assign n_prev   = n - LOGN'(1);
  assign busy     = (state != ST_IDLE);
  assign in_ready = !busy;

  // shared multiply-accumulate
  logic signed [EW-1:0]  acc_fa, acc_bb;
  logic signed [ACW-1:0] acc_num;
  logic [ACW-1:0]        acc_den;
  logic acc_en, acc_clr;

  always_comb begin
    acc_fa = '0;
    acc_bb = '0;
    if (state == ST_LOAD) begin
      acc_fa = EW'(x_mem[n]);
    end else if (state == ST_ACC) begin
      acc_fa = f_mem[n];
      acc_bb = b_mem[n_prev];
    end
  end

  assign acc_en  = (state == ST_LOAD) || (state == ST_ACC);
  assign acc_clr = (state == ST_IDLE) || (state == ST_PZ) || (state == ST_COEF);

  burg_acc #(.EW(EW), .ACW(ACW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en),
    .fa(acc_fa), .bb(acc_bb), .num(acc_num), .den(acc_den)
  );

  // reflection divider
  logic div_start, div_vld;
  logic signed [KW-1:0] div_k;
  assign div_start = (state == ST_DST);

  burg_div #(.ACW(ACW), .KW(KW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(acc_num), .den(acc_den), .vld(div_vld), .k(div_k)
  );

  // lattice error update
  logic signed [EW-1:0] f_old, b_old, f_new, b_new;
  logic signed [KW+EW-1:0] pkb, pkf;

  always_comb begin
    f_old = f_mem[n];
    b_old = b_mem[n_prev];
    pkb   = k_q * b_old;
    pkf   = k_q * f_old;
    f_new = f_old + EW'(pkb >>> FR);
    b_new = b_old + EW'(pkf >>> FR);
  end

  // coefficient mirror products, all taken from the old set
  logic signed [KW+CW-1:0] cprod [P];
  logic signed [CW-1:0]    mirror;

  always_comb begin
    for (int i = 1; i <= P; i++) begin
      mirror = '0;
      for (int t = 0; t < P; t++) begin
        if (t == int'(m) - i - 1) mirror = coef[t];
      end
      cprod[i-1] = k_q * mirror;
    end
  end

  // error power update
  logic signed [2*KW-1:0] ksq;
  logic [2*KW+PW-1:0]     pprod;

  always_comb begin
    ksq      = k_q * k_q;
    pprod    = {{PW{1'b0}}, $unsigned(ksq)} * {{(2*KW){1'b0}}, pwr};
    pwr_next = pwr - PW'(pprod >> (2 * FR));
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) x_mem[in_addr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (state == ST_LOAD) begin
      f_mem[n] <= EW'(x_mem[n]);
      b_mem[n] <= EW'(x_mem[n]);
    end else if (state == ST_UPD) begin
      f_mem[n] <= f_new;
      b_mem[n] <= b_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      n     <= '0;
      m     <= '0;
      pwr   <= '0;
      k_q   <= '0;
      done  <= 1'b0;
      for (int i = 0; i < P; i++) coef[i] <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          n     <= '0;
          pwr   <= '0;
          for (int i = 0; i < P; i++) coef[i] <= '0;
        end
        ST_LOAD: begin
          n <= n + LOGN'(1);
          if (n == LOGN'(N - 1)) state <= ST_PZ;
        end
        ST_PZ: begin
          pwr   <= PW'(acc_den >> LOGN);
          m     <= MW'(1);
          n     <= LOGN'(1);
          state <= ST_ACC;
        end
        ST_ACC: begin
          if (n == LOGN'(N - 1)) state <= ST_DST;
          else n <= n + LOGN'(1);
        end
        ST_DST: state <= ST_DWT;
        ST_DWT: if (div_vld) begin
          k_q   <= div_k;
          state <= ST_COEF;
        end
        ST_COEF: begin
          for (int i = 1; i <= P; i++) begin
            if (i < int'(m)) coef[i-1] <= coef[i-1] + CW'(cprod[i-1] >>> FR);
            else if (i == int'(m)) coef[i-1] <= CW'(k_q);
          end
          pwr <= pwr_next;
          if (m == MW'(P)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            n     <= LOGN'(N - 1);
            state <= ST_UPD;
          end
        end
        ST_UPD: begin
          if (n == LOGN'(m)) begin
            m     <= m + MW'(1);
            n     <= LOGN'(m) + LOGN'(1);
            state <= ST_ACC;
          end else begin
            n <= n - LOGN'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < P; i++) begin
      if (int'(rd_addr) == i) rd_data = {{(DW-CW){coef[i][CW-1]}}, coef[i]};
    end
    if (int'(rd_addr) == P) rd_data = pwr;
  end
endmodule

// File: rtl/burg_ar_chk.sv
module burg_ar_chk #(
  parameter int KW  = 16,
  parameter int RAW = 3,
  parameter int DW  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [RAW-1:0]       rd_addr,
  input logic [DW-1:0]        rd_data,
  input logic                 k_vld,
  input logic signed [KW-1:0] k_val
);
  localparam logic signed [KW-1:0] KMIN = {1'b1, {(KW-1){1'b0}}};

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5
  k_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    k_vld |-> (k_val != KMIN));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

bind burg_ar_est burg_ar_chk #(
  .KW(burg_pkg::BURG_KW), .RAW($clog2(P+2)), .DW(2*W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_addr(rd_addr), .rd_data(rd_data), .k_vld(div_vld), .k_val(div_k)
);

// File: tb/burg_ar_est_test.sv
`timescale 1ns/1ps
module burg_ar_est_test;
  localparam int N     = 64;
  localparam int P     = 4;
  localparam int W     = 16;
  localparam int LOGN  = $clog2(N);
  localparam int RAW   = $clog2(P + 2);
  localparam int DW    = 2 * W;
  localparam int BOUND = 2 * N * (P + 1) + 20 * P + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [LOGN-1:0] in_addr = '0;
  logic signed [W-1:0] in_data = '0;
  logic [RAW-1:0] rd_addr = '0;
  logic busy, done, in_ready;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  burg_ar_est #(.N(N), .P(P), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_data(in_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  int mon_runs = 0;
  bit finished = 0;
  real exp_q[$];
  real tol_q[$];
  string tag_q[$];
  real last_rd [P+1];
  int xs [N];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input real act, input real expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0f expected=%0f", tag, what, act, expv);
    end
  endtask

  function automatic int noise();
    lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
    return int'($signed(lfsr));
  endfunction

  task automatic push(input real e, input real t, input string tg);
    exp_q.push_back(e);
    tol_q.push_back(t);
    tag_q.push_back(tg);
  endtask

  // floating-point Burg fit built from the requirement formulas
  task automatic ref_fit();
    real f [N];
    real b [N];
    real a [P+1];
    real an [P+1];
    real num, den, k, pw, kmax;
    kmax = 32767.0 / 32768.0;
    pw = 0.0;
    for (int n = 0; n < N; n++) begin
      f[n] = xs[n];
      b[n] = xs[n];
      pw += f[n] * f[n];
    end
    pw = pw / N;
    for (int i = 0; i <= P; i++) a[i] = 0.0;
    for (int m = 1; m <= P; m++) begin
      num = 0.0;
      den = 0.0;
      for (int n = m; n < N; n++) begin
        num += f[n] * b[n-1];
        den += f[n] * f[n] + b[n-1] * b[n-1];
      end
      k = (den == 0.0) ? 0.0 : -2.0 * num / den;
      if (k > kmax) k = kmax;
      if (k < -kmax) k = -kmax;
      for (int i = 1; i < m; i++) an[i] = a[i] + k * a[m-i];
      for (int i = 1; i < m; i++) a[i] = an[i];
      a[m] = k;
      pw = (1.0 - k * k) * pw;
      for (int n = N - 1; n >= m; n--) begin
        real fo, bo;
        fo = f[n];
        bo = b[n-1];
        f[n] = fo + k * bo;
        b[n] = bo + k * fo;
      end
    end
    for (int i = 1; i <= P; i++) push(a[i], 0.02, "R4/R7");
    push(pw, 0.05 * pw + 8.0, "R8");
  endtask

  task automatic make_frame(input int mode);
    real y;
    y = 0.0;
    for (int n = 0; n < N; n++) begin
      case (mode)
        0: xs[n] = $rtoi(6000.0 * $sin(2.0 * 3.14159265 * 0.1 * n)) + (noise() >>> 6);
        1: begin
          y = 0.8 * y + $itor(noise() >>> 3);
          if (y > 30000.0) y = 30000.0;
          if (y < -30000.0) y = -30000.0;
          xs[n] = $rtoi(y);
        end
        2: xs[n] = 0;
        default: xs[n] = 1000;
      endcase
    end
  endtask

  task automatic run_case(input int mode, input bit write);
    int cnt;
    int prev;
    if (write) begin
      make_frame(mode);
      for (int n = 0; n < N; n++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = LOGN'(n);
        in_data  = W'(xs[n]);
        if (n == 0) check(in_ready === 1'b1, "R2", "in_ready idle", in_ready, 1);
      end
      @(negedge clk);
      in_valid = 1'b0;
    end
    if (mode <= 1) begin
      ref_fit();
    end else if (mode == 2) begin
      for (int i = 0; i < P; i++) push(0.0, 1e-9, "R6");
      push(0.0, 1e-9, "R8");
    end else begin
      push(-32767.0 / 32768.0, 1e-9, "R5");
      for (int i = 1; i < P; i++) push(0.0, 1e-9, "R6/R7");
      push(62.0, 1e-9, "R8");
    end
    prev = mon_runs;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R3", "busy after start", busy, 1);
    in_valid = 1'b1;
    in_addr  = '0;
    in_data  = 16'sd12345;
    check(in_ready === 1'b0, "R2", "in_ready while busy", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 2;
    while (done !== 1'b1 && cnt < BOUND) begin
      @(negedge clk);
      cnt++;
    end
    check(done === 1'b1, "R3", "done within bound", cnt, BOUND);
    check(busy === 1'b0, "R3", "busy low at done", busy, 0);
    cnt = 0;
    while (mon_runs == prev && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    if (mon_runs == prev) begin
      check(1'b0, "R3", "results not read", 0, 1);
      exp_q.delete();
      tol_q.delete();
      tag_q.delete();
    end
  endtask

  // monitor: read every result in the done cycle and compare with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (done === 1'b1) begin
        for (int i = 0; i <= P; i++) begin
          real act, e, t;
          string tg;
          rd_addr = RAW'(i);
          #1;
          if (i < P) act = $itor($signed(rd_data)) / 32768.0;
          else act = $itor(rd_data);
          last_rd[i] = act;
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected result", act, 0);
          end else begin
            e = exp_q.pop_front();
            t = tol_q.pop_front();
            tg = tag_q.pop_front();
            check((act - e <= t) && (e - act <= t), tg, $sformatf("result %0d", i), act, e);
          end
        end
        mon_runs++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "R3", "watchdog expired", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1", "busy at reset", busy, 0);
    check(done === 1'b0, "R1", "done at reset", done, 0);
    check(in_ready === 1'b1, "R1", "in_ready at reset", in_ready, 1);
    for (int i = 0; i <= P + 1; i++) begin
      rd_addr = RAW'(i);
      #1;
      check(rd_data === '0, "R1", "rd_data at reset", rd_data, 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case(0, 1'b1);   // tone plus noise, R4 R7 R8
    run_case(1, 1'b1);   // first-order correlated noise, R4 R7 R8
    run_case(2, 1'b1);   // silent frame, R6
    run_case(3, 1'b1);   // constant frame saturates k1, R5
    run_case(3, 1'b0);   // same buffer again, busy write ignored, R10 R2

    // R9: results hold long after done
    repeat (30) @(negedge clk);
    for (int i = 0; i <= P; i++) begin
      real act;
      rd_addr = RAW'(i);
      #1;
      if (i < P) act = $itor($signed(rd_data)) / 32768.0;
      else act = $itor(rd_data);
      check(act == last_rd[i], "R9", $sformatf("hold %0d", i), act, last_rd[i]);
    end
    rd_addr = RAW'(P + 1);
    #1;
    check(rd_data === '0, "R9", "unused address", rd_data, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule